// File: doc/BRIEF.md
# Double-Buffered Frame Base Address Registers

This block holds the frame-buffer start addresses that a display DMA engine fetches from. There is one address for the upper panel and one for the lower panel. The upper address serves single-panel and TFT displays as well as the top half of a dual panel. The lower address serves only the bottom half of a dual panel. Each address exists twice: a programmed copy that software writes over a simple register bus at any moment, and an active copy that drives the DMA fetch logic.

Active copies change only on the rising edge of the vertical-sync input. On that edge both programmed values move into the active registers together. The same edge sets a sticky "update done" flag, which tells software it may now load the next buffer addresses. An enable bit can turn that flag into a level interrupt. Software can therefore flip between frame buffers mid-frame with no tearing. It writes the new addresses whenever it likes, and they take effect from the next frame onward.

All register offsets are byte addresses on the bus. Reads are combinational from the address presented in the same cycle. A write is committed on the clock edge at which the write enable is sampled high.

Top module: `fbase_vsync_regs`

## Requirements
- R1: After reset, both base outputs, the interrupt and every register readback are 0.
- R2: A write to offset 0x10 (upper) or 0x14 (lower) stores data bits 31:2 in the programmed register. Bits 1:0 are discarded and always read back as 0.
- R3: Writes to the programmed registers leave the base outputs unchanged. At the clock edge where vertical sync is first sampled high after being low, both outputs take the programmed values held before that edge, and they show those values from the next cycle on.
- R4: A vertical-sync pulse held high for several cycles causes exactly one copy. A programmed write made while the pulse is still high does not reach the output until the next rising edge.
- R5: Each copy sets the update-done flag, read as bit 0 at offset 0x1C. Writing 1 to bit 0 of 0x1C clears it, and writing 0 there has no effect.
- R6: If a copy and a clear of the flag fall in the same cycle, the flag ends up set.
- R7: The interrupt output is high exactly while the update-done flag and the interrupt-enable bit are both 1. The enable bit is bit 0 at offset 0x18 and is read back there. The interrupt stays high until the flag is cleared or the enable is removed.
- R8: Only bit 0 of offset 0x18 is stored. Reads of any offset other than 0x10, 0x14, 0x18 and 0x1C return 0.
- R9: A programmed write in the same cycle as a copy makes the output take the old programmed value. The new value is stored and reaches the output at the following sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Vertical-sync level from the timing generator |
| reg_addr_i | input | ADDR_W (8) | Register byte offset |
| reg_wr_i | input | 1 | Write enable, one cycle per write |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data for reg_addr_i |
| base_upper_o | output | DATA_W (32) | Active upper-panel base address |
| base_lower_o | output | DATA_W (32) | Active lower-panel base address |
| irq_o | output | 1 | Level interrupt: update done and enabled |

## Verification
The bench holds vertical sync high across several cycles and writes a new address mid-pulse. A design that triggered on level instead of edge would copy repeatedly and show that address too early. It writes an address in the very cycle of the sync edge, where a design that forwarded write data into the active copy would show the new value one frame early. It also issues a flag clear together with a copy, where clear-priority logic would lose the update notice. Finally it writes all-ones to the address and control registers, which exposes any failure to discard the two low address bits or the unused control bits.

// File: rtl/fbase_pkg.sv
package fbase_pkg;
    localparam int unsigned NUM_PANELS   = 2;
    localparam int unsigned PANEL_UPPER  = 0;
    localparam int unsigned PANEL_LOWER  = 1;
    localparam int unsigned OFS_BASE0    = 'h10;
    localparam int unsigned OFS_STRIDE   = 4;
    localparam int unsigned OFS_CTRL     = 'h18;
    localparam int unsigned OFS_STAT     = 'h1C;
endpackage

// File: rtl/fbase_vsync_edge.sv
module fbase_vsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_i,
    output logic copy_o
);
    typedef struct packed {
        logic vs_prev;
    } edge_t;

    edge_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.vs_prev = vsync_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign copy_o = vsync_i & ~st_q.vs_prev;

    // R4
    single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_o |=> !copy_o);
endmodule

// File: rtl/fbase_panel_reg.sv
module fbase_panel_reg #(
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              copy_i,
    output logic [DATA_W-1:0] prog_o,
    output logic [DATA_W-1:0] active_o
);
    localparam logic [DATA_W-1:0] KEEP_MASK =
        {{(DATA_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    typedef struct packed {
        logic [DATA_W-1:0] prog;
        logic [DATA_W-1:0] active;
    } panel_t;

    panel_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i)   st_d.prog   = wdata_i & KEEP_MASK;
        if (copy_i) st_d.active = st_q.prog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prog_o   = st_q.prog;
    assign active_o = st_q.active;

    // R3
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_i |=> $stable(active_o));
    // R9
    active_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_i |=> active_o == $past(prog_o));
endmodule

// File: rtl/fbase_ctrl.sv
module fbase_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr_i,
    input  logic stat_wr_i,
    input  logic wbit_i,
    input  logic copy_i,
    output logic ien_o,
    output logic done_o,
    output logic irq_o
);
    typedef struct packed {
        logic ien;
        logic done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctrl_wr_i)            st_d.ien  = wbit_i;
        if (stat_wr_i && wbit_i)  st_d.done = 1'b0;
        if (copy_i)               st_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ien_o  = st_q.ien;
    assign done_o = st_q.done;
    assign irq_o  = st_q.done & st_q.ien;

    // R6
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copy_i |=> done_o);
    // R5
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr_i && wbit_i && !copy_i) |=> !done_o);
    // R7
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_i && ien_o && !ctrl_wr_i) |=> irq_o);
endmodule

// File: rtl/fbase_vsync_regs.sv
module fbase_vsync_regs #(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic [DATA_W-1:0] base_upper_o,
    output logic [DATA_W-1:0] base_lower_o,
    output logic              irq_o
);
    import fbase_pkg::*;

    localparam logic [ADDR_W-1:0] ADR_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] ADR_STAT = ADDR_W'(OFS_STAT);

    logic              copy_w;
    logic              ien_w;
    logic              done_w;
    logic [DATA_W-1:0] prog_w   [NUM_PANELS];
    logic [DATA_W-1:0] active_w [NUM_PANELS];
    logic [NUM_PANELS-1:0] panel_hit;

    fbase_vsync_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .vsync_i (vsync_i),
        .copy_o  (copy_w)
    );

    for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
        localparam logic [ADDR_W-1:0] ADR_P = ADDR_W'(OFS_BASE0 + OFS_STRIDE * p);
        assign panel_hit[p] = (reg_addr_i == ADR_P);

        fbase_panel_reg #(
            .DATA_W     (DATA_W),
            .ALIGN_BITS (ALIGN_BITS)
        ) u_panel (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_i     (reg_wr_i && panel_hit[p]),
            .wdata_i  (reg_wdata_i),
            .copy_i   (copy_w),
            .prog_o   (prog_w[p]),
            .active_o (active_w[p])
        );
    end

    fbase_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr_i (reg_wr_i && reg_addr_i == ADR_CTRL),
        .stat_wr_i (reg_wr_i && reg_addr_i == ADR_STAT),
        .wbit_i    (reg_wdata_i[0]),
        .copy_i    (copy_w),
        .ien_o     (ien_w),
        .done_o    (done_w),
        .irq_o     (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        for (int p = 0; p < NUM_PANELS; p++) begin
            if (panel_hit[p]) reg_rdata_o = prog_w[p];
        end
        if (reg_addr_i == ADR_CTRL) reg_rdata_o = DATA_W'(ien_w);
        if (reg_addr_i == ADR_STAT) reg_rdata_o = DATA_W'(done_w);
    end

    assign base_upper_o = active_w[PANEL_UPPER];
    assign base_lower_o = active_w[PANEL_LOWER];

    // R2
    rdata_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|panel_hit) |-> reg_rdata_o[ALIGN_BITS-1:0] == '0);
    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|panel_hit) && reg_addr_i != ADR_CTRL && reg_addr_i != ADR_STAT)
        |-> reg_rdata_o == '0);
    // R3
    outputs_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync_i || $past(vsync_i)) |=> $stable(base_upper_o) && $stable(base_lower_o));
endmodule

// File: tb/fbase_vsync_regs_tb.sv
module fbase_vsync_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, bup, blo;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    fbase_vsync_regs u_dut (
        .clk (clk), .rst_n (rst_n), .vsync_i (vsync),
        .reg_addr_i (addr), .reg_wr_i (wr), .reg_wdata_i (wdata),
        .reg_rdata_o (rdata), .base_upper_o (bup), .base_lower_o (blo),
        .irq_o (irq)
    );

    typedef struct packed {
        logic [31:0] up;
        logic [31:0] lo;
        logic        sync;
        logic [31:0] eu;
        logic [31:0] el;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h1000_0003, 32'h2000_0001, 1'b0, 32'h0000_0000, 32'h0000_0000},
        '{32'h1000_0003, 32'h2000_0001, 1'b1, 32'h1000_0000, 32'h2000_0000},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 32'h1000_0000, 32'h2000_0000},
        '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 32'hAAAA_AAA8, 32'h5555_5554},
        '{32'hFFFF_FFFF, 32'h0000_0004, 1'b1, 32'hFFFF_FFFC, 32'h0000_0004},
        '{32'h0000_0000, 32'h0000_0000, 1'b1, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic pulse(input int len);
        @(negedge clk);
        vsync = 1'b1;
        repeat (len) @(negedge clk);
        vsync = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 upper", bup, 32'h0);
        chk("R1 lower", blo, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        rd_chk("R1 rd upper", 8'h10, 32'h0);
        rd_chk("R1 rd lower", 8'h14, 32'h0);
        rd_chk("R1 rd ctrl", 8'h18, 32'h0);
        rd_chk("R1 rd stat", 8'h1C, 32'h0);

        // R2 R3 vector walk
        foreach (VECS[i]) begin
            wr_reg(8'h10, VECS[i].up);
            wr_reg(8'h14, VECS[i].lo);
            rd_chk("R2 prog upper", 8'h10, VECS[i].up & 32'hFFFF_FFFC);
            rd_chk("R2 prog lower", 8'h14, VECS[i].lo & 32'hFFFF_FFFC);
            if (VECS[i].sync) pulse(1);
            @(negedge clk);
            chk("R3 upper out", bup, VECS[i].eu);
            chk("R3 lower out", blo, VECS[i].el);
        end

        // R4 long pulse, write mid-pulse
        wr_reg(8'h10, 32'h0000_1000);
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        chk("R4 copied at rise", bup, 32'h0000_1000);
        addr = 8'h10; wdata = 32'h0000_2000; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
        repeat (3) @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
        chk("R4 no second copy", bup, 32'h0000_1000);
        pulse(1);
        @(negedge clk);
        chk("R4 next edge copies", bup, 32'h0000_2000);

        // R5 flag set / clear
        rd_chk("R5 flag set", 8'h1C, 32'h1);
        wr_reg(8'h1C, 32'h0);
        rd_chk("R5 write 0 ignored", 8'h1C, 32'h1);
        wr_reg(8'h1C, 32'h1);
        rd_chk("R5 write 1 clears", 8'h1C, 32'h0);

        // R7 interrupt masking
        pulse(1);
        @(negedge clk);
        chk("R7 masked irq", {31'h0, irq}, 32'h0);
        wr_reg(8'h18, 32'h1);
        @(negedge clk);
        chk("R7 enabled irq", {31'h0, irq}, 32'h1);
        repeat (4) @(negedge clk);
        chk("R7 irq level held", {31'h0, irq}, 32'h1);
        wr_reg(8'h1C, 32'h1);
        @(negedge clk);
        chk("R7 irq after clear", {31'h0, irq}, 32'h0);

        // R6 set wins over clear
        @(negedge clk);
        vsync = 1'b1; addr = 8'h1C; wdata = 32'h1; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; vsync = 1'b0;
        rd_chk("R6 set wins", 8'h1C, 32'h1);
        chk("R6 irq with set", {31'h0, irq}, 32'h1);
        wr_reg(8'h1C, 32'h1);

        // R8 reserved control bits and unmapped offsets
        wr_reg(8'h18, 32'hFFFF_FFFE);
        rd_chk("R8 ctrl bit0 only", 8'h18, 32'h0);
        wr_reg(8'h18, 32'hFFFF_FFFF);
        rd_chk("R8 ctrl readback", 8'h18, 32'h1);
        wr_reg(8'h40, 32'hDEAD_BEEF);
        rd_chk("R8 unmapped 0x40", 8'h40, 32'h0);
        rd_chk("R8 unmapped 0x00", 8'h00, 32'h0);
        rd_chk("R8 upper untouched", 8'h10, 32'h0000_2000);

        // R9 write coinciding with sync edge
        wr_reg(8'h14, 32'h0000_3000);
        @(negedge clk);
        vsync = 1'b1; addr = 8'h14; wdata = 32'h0000_4000; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; vsync = 1'b0;
        chk("R9 output takes old", blo, 32'h0000_3000);
        rd_chk("R9 prog takes new", 8'h14, 32'h0000_4000);
        pulse(1);
        @(negedge clk);
        chk("R9 new at next edge", blo, 32'h0000_4000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule